// File: doc/BRIEF.md
# Boot-block flash command controller

This block is the command front end and write state machine of a small boot-block NOR flash. A host drives a plain memory bus (chip enable, write enable, output enable, address, data). Command writes are latched when write enable rises while chip enable is low. They select what reads return: array contents or the status byte. They also start program and erase jobs, which run for a fixed number of clock cycles against a scaled-down internal array.

The array is split into seven erase blocks of unequal size. The topmost block holds boot code and is hardware-locked. A program or erase aimed at it is refused unless the write-protect input is high or the power-down input is driven to its unlock level. The active-low power-down input drops any running job, blanks the bus and returns the block to array reads. A width select picks 16-bit access or 8-bit access. In 8-bit access one extra address bit picks the byte.

Top module: `flash_boot_ctrl`

## Requirements
- R1: After `rst_ni` is released, every word reads 0xFFFF, reads return array data without any command, and the status byte reads 0x80.
- R2: While `pd_ni` is low, `dout_o` is 0 and all writes are ignored. A running program or erase stops and leaves the array unchanged. Once `pd_ni` is high again, reads return array data and the status byte is 0x80.
- R3: A program is the write 0x40 followed by a data write, and acts on the address of the data write. An erase is 0x20 followed by 0xD0, and acts on the block holding the address of the 0xD0 write.
- R4: A program stores the bitwise AND of the data and the old contents at one location only. Every other location keeps its value.
- R5: An erase sets every word of the selected block to 0xFFFF. Words outside that block are left unchanged.
- R6: With U = `UNIT_WORDS`, the blocks counted upward from word 0 have sizes 16U, 16U, 16U, 12U, U, U and 2U words. The last block, at the top of the address space, is the boot block.
- R7: When `wp_ni` and `pd_unlock_i` are both low, a program aimed at the boot block sets status bits 3 and 4, and an erase aimed at it sets bits 3 and 5. Neither changes the array or makes the block busy. If either input is high, the operation proceeds.
- R8: When `byte_ni` is low, `dout_o[15:8]` is 0 and `dout_o[7:0]` returns the low byte if `addr_lsb_i` is 0 or the high byte if it is 1. A program then changes only that byte, using `din_i[7:0]`.
- R9: A program keeps the block busy for `PROG_CYCLES` cycles and an erase for `ERASE_CYCLES` cycles. While busy, status bit 7 is 0, every read returns the status byte whatever the address, and writes are ignored.
- R10: The status byte is 0x00 on `dout_o[15:8]` and {ready, 0, erase error, program error, lock error, 0, 0, 0} on `dout_o[7:0]`. The error bits stay set until the command 0x50. The command 0x70 selects status reads and 0xFF selects array reads.
- R11: If the write after 0x20 is any byte other than 0xD0, status bits 5 and 4 are set and no erase starts.
- R12: Once a program or erase has finished, reads keep returning the status byte until 0xFF is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| pd_ni | input | 1 | Power-down/abort, active low |
| pd_unlock_i | input | 1 | Power-down pin held at unlock level; opens the boot block |
| wp_ni | input | 1 | Write protect, active low; high opens the boot block |
| byte_ni | input | 1 | Low selects 8-bit access |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low; write latched on its rise |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | AW | Word address |
| addr_lsb_i | input | 1 | Byte select in 8-bit access |
| din_i | input | 16 | Write data and command code (low byte) |
| dout_o | output | 16 | Read data |

## Verification
The hardest case to reach from the ports is a power-down in the middle of an erase. The erase must stop with the block untouched, and writes made while the pin is low must leave no trace once it is released. The bench programs a word to zero, starts an erase of that word's block, and drops `pd_ni` a few cycles later. While the pin is low it issues a complete program sequence. After release it checks that the zeroed word survived, that the ignored program left its target blank, and that reads return array data rather than status. Random jobs with random width, address, data and protect settings cover the block boundaries and the lock paths.

// File: rtl/flash_boot_pkg.sv
package flash_boot_pkg;
  localparam int BLK_W       = 3;
  localparam int TOTAL_UNITS = 64;
  localparam logic [BLK_W-1:0] BOOT_BLK = 3'd6;

  localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP   = 8'h40;
  localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
  localparam logic [7:0] CMD_ERASE_GO     = 8'hD0;

  localparam int SR_READY = 7;

  typedef enum logic [1:0] {
    CUI_IDLE,
    CUI_PROG_ARM,
    CUI_ERASE_ARM
  } cui_state_e;

  // unit = 1/64 of the array; block sizes in units: 16,16,16,12,1,1,2
  function automatic logic [BLK_W-1:0] unit_to_blk(input int unsigned unit);
    if (unit < 32'd48)       return BLK_W'(unit / 32'd16);
    else if (unit < 32'd60)  return 3'd3;
    else if (unit == 32'd60) return 3'd4;
    else if (unit == 32'd61) return 3'd5;
    else                     return BOOT_BLK;
  endfunction

  function automatic int unsigned blk_base_unit(input logic [BLK_W-1:0] blk);
    case (blk)
      3'd0:    return 32'd0;
      3'd1:    return 32'd16;
      3'd2:    return 32'd32;
      3'd3:    return 32'd48;
      3'd4:    return 32'd60;
      3'd5:    return 32'd61;
      default: return 32'd62;
    endcase
  endfunction
endpackage

// File: rtl/flash_cui.sv
module flash_cui
  import flash_boot_pkg::*;
#(
  parameter int AW      = 8,
  parameter int UNIT_SH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_ni,
  input  logic          wr_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_code_i,
  input  logic          busy_i,
  input  logic          unlock_i,
  output logic          start_prog_o,
  output logic          start_erase_o,
  output logic          rd_status_o,
  output logic [7:0]    sr_o
);
  cui_state_e state_q, state_d;
  logic rd_status_q, rd_status_d;
  logic err_erase_q, err_erase_d;
  logic err_prog_q, err_prog_d;
  logic err_lock_q, err_lock_d;
  logic accept, boot_hit, locked;
  logic [AW-UNIT_SH-1:0] unit_idx;

  assign accept   = wr_i && pd_ni && !busy_i;
  assign unit_idx = wr_addr_i[AW-1:UNIT_SH];
  assign boot_hit = unit_to_blk(32'(unit_idx)) == BOOT_BLK;
  assign locked   = boot_hit && !unlock_i;

  always_comb begin
    state_d       = state_q;
    rd_status_d   = rd_status_q;
    err_erase_d   = err_erase_q;
    err_prog_d    = err_prog_q;
    err_lock_d    = err_lock_q;
    start_prog_o  = 1'b0;
    start_erase_o = 1'b0;
    if (accept) begin
      unique case (state_q)
        CUI_PROG_ARM: begin
          state_d     = CUI_IDLE;
          rd_status_d = 1'b1;
          if (locked) begin
            err_lock_d = 1'b1;
            err_prog_d = 1'b1;
          end else begin
            start_prog_o = 1'b1;
          end
        end
        CUI_ERASE_ARM: begin
          state_d     = CUI_IDLE;
          rd_status_d = 1'b1;
          if (wr_code_i != CMD_ERASE_GO) begin
            err_erase_d = 1'b1;
            err_prog_d  = 1'b1;
          end else if (locked) begin
            err_lock_d  = 1'b1;
            err_erase_d = 1'b1;
          end else begin
            start_erase_o = 1'b1;
          end
        end
        default: begin
          case (wr_code_i)
            CMD_READ_STATUS: rd_status_d = 1'b1;
            CMD_CLEAR_STATUS: begin
              err_erase_d = 1'b0;
              err_prog_d  = 1'b0;
              err_lock_d  = 1'b0;
            end
            CMD_PROG_SETUP: begin
              state_d     = CUI_PROG_ARM;
              rd_status_d = 1'b1;
            end
            CMD_ERASE_SETUP: begin
              state_d     = CUI_ERASE_ARM;
              rd_status_d = 1'b1;
            end
            default: rd_status_d = 1'b0;
          endcase
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= CUI_IDLE;
      rd_status_q <= 1'b0;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_lock_q  <= 1'b0;
    end else if (!pd_ni) begin
      state_q     <= CUI_IDLE;
      rd_status_q <= 1'b0;
      err_erase_q <= 1'b0;
      err_prog_q  <= 1'b0;
      err_lock_q  <= 1'b0;
    end else begin
      state_q     <= state_d;
      rd_status_q <= rd_status_d;
      err_erase_q <= err_erase_d;
      err_prog_q  <= err_prog_d;
      err_lock_q  <= err_lock_d;
    end
  end

  assign rd_status_o = rd_status_q;
  assign sr_o = {!busy_i, 1'b0, err_erase_q, err_prog_q, err_lock_q, 3'b000};

  // R11
  seq_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && state_q == CUI_ERASE_ARM && wr_code_i != CMD_ERASE_GO
    |=> err_erase_q && err_prog_q);

  // R7
  lock_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && state_q == CUI_PROG_ARM && locked |=> err_lock_q && err_prog_q);

  // R10
  sticky_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_lock_q && pd_ni && !(accept && state_q == CUI_IDLE && wr_code_i == CMD_CLEAR_STATUS)
    |=> err_lock_q);
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm #(
  parameter int AW           = 8,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_ni,
  input  logic          start_prog_i,
  input  logic          start_erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  input  logic          byte_i,
  input  logic          lsb_i,
  output logic          busy_o,
  output logic          commit_o,
  output logic          erase_o,
  output logic [AW-1:0] op_addr_o,
  output logic [15:0]   op_data_o,
  output logic          op_byte_o,
  output logic          op_lsb_o
);
  localparam int MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q, erase_q, byte_q, lsb_q;
  logic [AW-1:0] addr_q;
  logic [15:0]   data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      busy_q  <= 1'b0;
      erase_q <= 1'b0;
      byte_q  <= 1'b0;
      lsb_q   <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (!pd_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_prog_i || start_erase_i) begin
      busy_q  <= 1'b1;
      erase_q <= start_erase_i;
      cnt_q   <= start_erase_i ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
      addr_q  <= addr_i;
      data_q  <= data_i;
      byte_q  <= byte_i;
      lsb_q   <= lsb_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o    = busy_q;
  assign commit_o  = busy_q && (cnt_q == '0) && pd_ni;
  assign erase_o   = erase_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
  assign op_byte_o = byte_q;
  assign op_lsb_o  = lsb_q;

  // R2
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |=> !busy_q);

  // R9
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_prog_i || start_erase_i) |-> !busy_q);

  // R9
  count_down_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && cnt_q != '0 && pd_ni |=> busy_q && cnt_q == $past(cnt_q) - 1'b1);

  // R3
  one_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({start_prog_i, start_erase_i}));
endmodule

// File: rtl/flash_array.sv
module flash_array
  import flash_boot_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int AW      = 8,
  parameter int UNIT_SH = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          commit_i,
  input  logic          erase_i,
  input  logic [AW-1:0] addr_i,
  input  logic [15:0]   data_i,
  input  logic          byte_i,
  input  logic          lsb_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [15:0]   rd_data_o
);
  logic [15:0]        words [DEPTH];
  logic [15:0]        pmask;
  logic [BLK_W-1:0]   tgt_blk;
  logic [AW-UNIT_SH-1:0] tgt_unit;
  logic [AW-1:0]      tgt_base;

  assign tgt_unit = addr_i[AW-1:UNIT_SH];
  assign tgt_blk  = unit_to_blk(32'(tgt_unit));
  assign tgt_base = AW'(blk_base_unit(tgt_blk) << UNIT_SH);

  always_comb begin
    if (!byte_i)    pmask = data_i;
    else if (lsb_i) pmask = {data_i[7:0], 8'hFF};
    else            pmask = {8'hFF, data_i[7:0]};
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic [BLK_W-1:0] WBLK = unit_to_blk(32'(i >> UNIT_SH));
    logic [15:0] word_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     word_q <= '1;
      else if (commit_i && erase_i && tgt_blk == WBLK) word_q <= '1;
      else if (commit_i && !erase_i && addr_i == AW'(i)) word_q <= word_q & pmask;
    end
    assign words[i] = word_q;
  end

  assign rd_data_o = words[rd_addr_i];

  // R5
  erase_base_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && erase_i |=> words[$past(tgt_base)] == 16'hFFFF);

  // R4
  prog_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i && !erase_i |=> (words[$past(addr_i)] & ~$past(pmask)) == 16'h0000);
endmodule

// File: rtl/flash_boot_ctrl.sv
module flash_boot_ctrl
  import flash_boot_pkg::*;
#(
  parameter int UNIT_WORDS   = 4,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 20,
  localparam int DEPTH   = TOTAL_UNITS * UNIT_WORDS,
  localparam int AW      = $clog2(DEPTH),
  localparam int UNIT_SH = $clog2(UNIT_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pd_ni,
  input  logic          pd_unlock_i,
  input  logic          wp_ni,
  input  logic          byte_ni,
  input  logic          ce_ni,
  input  logic          we_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_lsb_i,
  input  logic [15:0]   din_i,
  output logic [15:0]   dout_o
);
  logic          we_q, wr_stb, byte_mode, unlock;
  logic          start_prog, start_erase, rd_status, busy;
  logic          commit, op_erase, op_byte, op_lsb;
  logic [7:0]    sr;
  logic [AW-1:0] op_addr;
  logic [15:0]   op_data, arr_word, rd_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) we_q <= 1'b1;
    else         we_q <= we_ni;
  end

  assign wr_stb    = !ce_ni && we_ni && !we_q;
  assign byte_mode = !byte_ni;
  assign unlock    = wp_ni || pd_unlock_i;

  flash_cui #(.AW(AW), .UNIT_SH(UNIT_SH)) u_cui (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_ni        (pd_ni),
    .wr_i         (wr_stb),
    .wr_addr_i    (addr_i),
    .wr_code_i    (din_i[7:0]),
    .busy_i       (busy),
    .unlock_i     (unlock),
    .start_prog_o (start_prog),
    .start_erase_o(start_erase),
    .rd_status_o  (rd_status),
    .sr_o         (sr)
  );

  flash_wsm #(.AW(AW), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) u_wsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pd_ni        (pd_ni),
    .start_prog_i (start_prog),
    .start_erase_i(start_erase),
    .addr_i       (addr_i),
    .data_i       (din_i),
    .byte_i       (byte_mode),
    .lsb_i        (addr_lsb_i),
    .busy_o       (busy),
    .commit_o     (commit),
    .erase_o      (op_erase),
    .op_addr_o    (op_addr),
    .op_data_o    (op_data),
    .op_byte_o    (op_byte),
    .op_lsb_o     (op_lsb)
  );

  flash_array #(.DEPTH(DEPTH), .AW(AW), .UNIT_SH(UNIT_SH)) u_array (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (commit),
    .erase_i  (op_erase),
    .addr_i   (op_addr),
    .data_i   (op_data),
    .byte_i   (op_byte),
    .lsb_i    (op_lsb),
    .rd_addr_i(addr_i),
    .rd_data_o(arr_word)
  );

  always_comb begin
    if (busy || rd_status) rd_word = {8'h00, sr};
    else if (byte_mode)    rd_word = {8'h00, addr_lsb_i ? arr_word[15:8] : arr_word[7:0]};
    else                   rd_word = arr_word;
  end

  assign dout_o = (!ce_ni && !oe_ni && pd_ni) ? rd_word : 16'h0000;

  // R12
  hold_status_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) && pd_ni && $past(pd_ni) |-> rd_status);

  // R9
  busy_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !ce_ni && !oe_ni && pd_ni |-> !dout_o[SR_READY] && dout_o[15:8] == 8'h00);

  // R2
  pd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_ni |-> dout_o == 16'h0000);
endmodule

// File: tb/flash_boot_ctrl_bench.sv
`timescale 1ns/1ps
module flash_boot_ctrl_bench;
  localparam int UNIT_WORDS   = 4;
  localparam int PROG_CYCLES  = 6;
  localparam int ERASE_CYCLES = 20;
  localparam int DEPTH        = 64 * UNIT_WORDS;
  localparam int AW           = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_ni = 1'b0, pd_ni = 1'b1, pd_unlock = 1'b0, wp_ni = 1'b0, byte_ni = 1'b1;
  logic ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1, lsb = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;

  int checks = 0, errors = 0;
  logic [15:0] model [DEPTH];
  logic [7:0] sr_err = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  flash_boot_ctrl #(.UNIT_WORDS(UNIT_WORDS), .PROG_CYCLES(PROG_CYCLES),
                    .ERASE_CYCLES(ERASE_CYCLES)) u_flash_boot_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .pd_ni(pd_ni), .pd_unlock_i(pd_unlock),
    .wp_ni(wp_ni), .byte_ni(byte_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr), .addr_lsb_i(lsb), .din_i(din), .dout_o(dout));

  function automatic int blk_lo(int b);
    int u;
    case (b) 0: u = 0; 1: u = 16; 2: u = 32; 3: u = 48; 4: u = 60; 5: u = 61; 6: u = 62; default: u = 64; endcase
    return u * UNIT_WORDS;
  endfunction
  function automatic int blk_hi(int b);
    return blk_lo(b + 1) - 1;
  endfunction
  function automatic int blk_of(int a);
    for (int b = 0; b < 7; b++) if (a >= blk_lo(b) && a <= blk_hi(b)) return b;
    return 6;
  endfunction
  function automatic bit is_locked(int a);
    return blk_of(a) == 6 && !wp_ni && !pd_unlock;
  endfunction
  function automatic logic [15:0] exp_read(int a, bit l);
    if (byte_ni) return model[a];
    return {8'h00, l ? model[a][15:8] : model[a][7:0]};
  endfunction

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, bit l, logic [15:0] d);
    @(negedge clk);
    oe_ni = 1'b1; ce_ni = 1'b0; we_ni = 1'b0; addr = AW'(a); lsb = l; din = d;
    @(negedge clk);
    we_ni = 1'b1;
  endtask

  task automatic rd(int a, bit l, output logic [15:0] v);
    @(negedge clk);
    we_ni = 1'b1; ce_ni = 1'b0; oe_ni = 1'b0; addr = AW'(a); lsb = l;
    #1 v = dout;
  endtask

  task automatic wait_ready(output int n, output logic [15:0] st);
    n = 0;
    forever begin
      @(negedge clk);
      ce_ni = 1'b0; oe_ni = 1'b0; addr = AW'($urandom_range(DEPTH - 1));
      #1;
      if (dout[7]) break;
      n++;
      if (n > 1000) break;
    end
    st = dout;
  endtask

  task automatic do_prog(int a, bit l, logic [15:0] d);
    int n; logic [15:0] st, v, m;
    bit lk = is_locked(a);
    wr(a, l, 16'h0040);
    wr(a, l, d);
    wait_ready(n, st);
    if (lk) begin
      sr_err |= 8'h18;
      check("R7 locked program no busy", 16'(n), 16'd0);
    end else begin
      check("R9 program busy cycles", 16'(n), 16'(PROG_CYCLES));
      if (byte_ni) m = d;
      else m = l ? {d[7:0], 8'hFF} : {8'hFF, d[7:0]};
      model[a] = model[a] & m;
    end
    check("R10 status after program", st, {8'h00, 8'h80 | sr_err});
    rd((a + 1) % DEPTH, 1'b0, v);
    check("R12 status held after program", v, {8'h00, 8'h80 | sr_err});
    wr(0, 0, 16'h0050); sr_err = 8'h00;
    wr(0, 0, 16'h00FF);
    rd(a, l, v);
    check("R4 program readback", v, exp_read(a, l));
    rd((a + 1) % DEPTH, l, v);
    check("R4 neighbour untouched", v, exp_read((a + 1) % DEPTH, l));
  endtask

  task automatic do_erase(int b, logic [7:0] conf);
    int n; logic [15:0] st, v;
    int a = blk_lo(b) + $urandom_range(blk_hi(b) - blk_lo(b));
    bit lk = is_locked(a);
    wr(blk_lo(b), 0, 16'h0020);
    wr(a, 0, {8'h00, conf});
    wait_ready(n, st);
    if (conf != 8'hD0) begin
      sr_err |= 8'h30;
      check("R11 bad confirm no busy", 16'(n), 16'd0);
    end else if (lk) begin
      sr_err |= 8'h28;
      check("R7 locked erase no busy", 16'(n), 16'd0);
    end else begin
      check("R9 erase busy cycles", 16'(n), 16'(ERASE_CYCLES));
      for (int i = blk_lo(b); i <= blk_hi(b); i++) model[i] = 16'hFFFF;
    end
    check("R10 status after erase", st, {8'h00, 8'h80 | sr_err});
    wr(0, 0, 16'h0050); sr_err = 8'h00;
    wr(0, 0, 16'h00FF);
    rd(blk_lo(b), 0, v); check("R5 R6 block low edge", v, exp_read(blk_lo(b), 0));
    rd(blk_hi(b), 0, v); check("R5 R6 block high edge", v, exp_read(blk_hi(b), 0));
    if (b > 0) begin
      rd(blk_lo(b) - 1, 0, v); check("R6 lower neighbour", v, exp_read(blk_lo(b) - 1, 0));
    end
    if (b < 6) begin
      rd(blk_hi(b) + 1, 0, v); check("R6 upper neighbour", v, exp_read(blk_hi(b) + 1, 0));
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL R9 watchdog got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [15:0] v, st;
    int n;
    void'($urandom(32'h5EED));
    for (int i = 0; i < DEPTH; i++) model[i] = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    rd(0, 0, v);         check("R1 word 0 erased", v, 16'hFFFF);
    rd(DEPTH - 1, 0, v); check("R1 top word erased", v, 16'hFFFF);
    wr(0, 0, 16'h0070);
    rd(5, 0, v);         check("R1 R10 status at reset", v, 16'h0080);
    wr(0, 0, 16'h00FF);

    // R3 R4 word program, then R8 byte program
    do_prog(10, 0, 16'h1234);
    do_prog(10, 0, 16'hF0F0);
    byte_ni = 1'b0;
    do_prog(11, 1, 16'h000F);
    do_prog(11, 0, 16'h00A5);
    rd(11, 1, v); check("R8 high byte", v, {8'h00, model[11][15:8]});
    byte_ni = 1'b1;

    // R7 boot lock and both unlock paths, R10 sticky across good op
    wp_ni = 1'b0; pd_unlock = 1'b0;
    wr(DEPTH - 1, 0, 16'h0040); wr(DEPTH - 1, 0, 16'h0000);
    wait_ready(n, st); check("R7 lock status", st, 16'h0098);
    wr(20, 0, 16'h0040); wr(20, 0, 16'h0F0F); model[20] = 16'h0F0F;
    wait_ready(n, st); check("R10 errors sticky", st, 16'h0098);
    wr(0, 0, 16'h0050);
    rd(0, 0, v); check("R10 cleared", v, 16'h0080);
    wr(0, 0, 16'h00FF);
    rd(DEPTH - 1, 0, v); check("R7 boot unchanged", v, 16'hFFFF);
    wp_ni = 1'b1;
    do_prog(DEPTH - 1, 0, 16'h5A5A);
    wp_ni = 1'b0; pd_unlock = 1'b1;
    do_prog(DEPTH - 2, 0, 16'h3C3C);
    pd_unlock = 1'b0;
    do_erase(6, 8'hD0);

    // R11 bad confirm
    do_erase(2, 8'h55);

    // R9 write during busy ignored, reads give status
    wr(blk_lo(1), 0, 16'h0020); wr(blk_lo(1), 0, 16'h00D0);
    rd(0, 0, v); check("R9 busy read is status", v, 16'h0000);
    wr(7, 0, 16'h00FF);
    wait_ready(n, st);
    for (int i = blk_lo(1); i <= blk_hi(1); i++) model[i] = 16'hFFFF;
    rd(3, 0, v); check("R9 R12 FF ignored while busy", v, 16'h0080);
    wr(0, 0, 16'h00FF);

    // R2 power-down aborts erase, ignores writes
    do_prog(30, 0, 16'h0000);
    wr(30, 0, 16'h0020); wr(30, 0, 16'h00D0);
    repeat (3) @(negedge clk);
    pd_ni = 1'b0;
    rd(30, 0, v); check("R2 output blank", v, 16'h0000);
    wr(40, 0, 16'h0040); wr(40, 0, 16'h0000);
    @(negedge clk); pd_ni = 1'b1;
    rd(30, 0, v); check("R2 erase aborted, array mode", v, 16'h0000);
    rd(40, 0, v); check("R2 write ignored in power-down", v, 16'hFFFF);
    wr(0, 0, 16'h0070);
    rd(0, 0, v); check("R2 status after release", v, 16'h0080);
    wr(0, 0, 16'h00FF);

    // random mix
    for (int it = 0; it < 60; it++) begin
      byte_ni   = 1'($urandom_range(1));
      wp_ni     = 1'($urandom_range(3) == 0);
      pd_unlock = 1'($urandom_range(5) == 0);
      if ($urandom_range(3) == 0) begin
        byte_ni = 1'b1;
        do_erase($urandom_range(6), ($urandom_range(7) == 0) ? 8'h33 : 8'hD0);
      end else begin
        int a = ($urandom_range(3) == 0) ? blk_lo(6) + $urandom_range(2 * UNIT_WORDS - 1)
                                         : $urandom_range(DEPTH - 1);
        do_prog(a, 1'($urandom_range(1)), 16'($urandom));
      end
    end
    finish_run();
  end
endmodule